// File: doc/BRIEF.md
# Twin-Predicated Register Move Sequencer

This block turns one vectorised register-to-register move into a stream of scalar copy pairs. The move is described by an element count, a base register and a vector flag for each operand, and a separate predicate mask for each operand. On every clock cycle the sequencer produces at most one (source register, destination register) pair. It flags completion with a single-cycle done pulse.

Each operand has its own element pointer. A vector operand's pointer jumps to the next enabled element of its own mask. A scalar operand's pointer stays at element zero, and its mask is ignored. The k-th enabled source element is therefore paired with the k-th enabled destination element. This one mechanism covers all of the following move forms:

- broadcast, and broadcast into selected slots
- single-element extract and single-element insert
- plain copy
- compaction (gather), expansion (scatter), and both together

Register-file access, operand redirection and non-default element widths are handled outside this block.

Top module: `twin_pred_mv_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `busy`, `pair_valid` and `done` are low.
- R2: `start` is accepted only while `busy` is low. On acceptance all move operands are captured, and `busy` is high in the following cycle. A `start` seen while `busy` is high has no effect on the running move.
- R3: For a vector source, the element index used for each copy is the lowest set bit of `src_pred` (bit k = element k) at or above the current source pointer. The pointer then moves one past that bit.
- R4: For a vector destination, the element index follows the same rule using `dst_pred` and its own pointer.
- R5: Copy number k pairs the k-th enabled source element with the k-th enabled destination element. Each register number is its base plus the element index, taken modulo 2^REG_W.
- R6: A scalar operand always uses element 0, which is its base register. Its predicate has no effect.
- R7: The move ends without a copy as soon as either selected index would be VL or more. `done` is then high for exactly one cycle, in the cycle after the last copy, or in the second cycle after acceptance if no copy is made. VL = 0 produces no copies.
- R8: With both operands scalar and VL of at least 1, exactly one copy is produced.
- R9: Copies come out one per cycle with no gaps. The first copy is visible in the second cycle after acceptance.
- R10: `busy` stays high from the cycle after acceptance until it falls together with the rise of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a move (accepted only while idle) |
| vl | input | IW | Element count of the move, 0..MAXVL |
| src_pred | input | MAXVL | Source predicate, bit k enables element k |
| dst_pred | input | MAXVL | Destination predicate, bit k enables element k |
| src_base | input | REG_W | Source base register number |
| dst_base | input | REG_W | Destination base register number |
| src_vec | input | 1 | Source is a vector operand |
| dst_vec | input | 1 | Destination is a vector operand |
| busy | output | 1 | A move is being sequenced |
| pair_valid | output | 1 | A copy pair is presented this cycle |
| pair_src | output | REG_W | Source register of the copy |
| pair_dst | output | REG_W | Destination register of the copy |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The bench builds the sequencer with MAXVL = 8 and REG_W = 5. With 8-bit masks, random draws regularly produce empty, full, one-hot and sparse predicates, so every mix of skips and early ends gets exercised. Bases drawn near 31 drive the base-plus-index sum past the top of the register space, which exercises the wrap-around. Directed moves cover each named move form, VL of zero and of MAXVL, and a second start arriving mid-move.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/tpm_next_set.sv
// Lowest set bit of mask at or above position 'from'; returns MAXVL if none.
module tpm_next_set #(
  parameter int MAXVL = 16,
  parameter int IW    = $clog2(MAXVL + 1)
) (
  input  logic [MAXVL-1:0] mask,
  input  logic [IW-1:0]    from,
  output logic [IW-1:0]    pos
);
  always_comb begin
    pos = IW'(MAXVL);
    for (int k = MAXVL - 1; k >= 0; k--) begin
      if (mask[k] && (IW'(k) >= from)) pos = IW'(k);
    end
  end
endmodule

// File: rtl/tpm_lane.sv
// One operand: captured flags, element pointer and register formation.
module tpm_lane #(
  parameter int MAXVL = 16,
  parameter int REG_W = 5,
  parameter int IW    = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             vec_in,
  input  logic [MAXVL-1:0] pred_in,
  input  logic [REG_W-1:0] base_in,
  output logic             vec,
  output logic [IW-1:0]    nxt,
  output logic [REG_W-1:0] reg_no
);
  logic [MAXVL-1:0] pred_q;
  logic [REG_W-1:0] base_q;
  logic [IW-1:0]    ptr_q;
  logic [IW-1:0]    hit;

  tpm_next_set #(.MAXVL(MAXVL), .IW(IW)) u_find (
    .mask (pred_q),
    .from (ptr_q),
    .pos  (hit)
  );

  // a scalar operand ignores its predicate and holds its pointer
  assign nxt    = vec ? hit : ptr_q;
  assign reg_no = base_q + REG_W'(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec    <= 1'b0;
      pred_q <= '0;
      base_q <= '0;
      ptr_q  <= '0;
    end else if (load) begin
      vec    <= vec_in;
      pred_q <= pred_in;
      base_q <= base_in;
      ptr_q  <= '0;
    end else if (step && vec) begin
      ptr_q  <= nxt + IW'(1);
    end
  end
endmodule

// File: rtl/twin_pred_mv_seq.sv
module twin_pred_mv_seq #(
  parameter int MAXVL = 16,
  parameter int REG_W = 5,
  localparam int IW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IW-1:0]    vl,
  input  logic [MAXVL-1:0] src_pred,
  input  logic [MAXVL-1:0] dst_pred,
  input  logic [REG_W-1:0] src_base,
  input  logic [REG_W-1:0] dst_base,
  input  logic             src_vec,
  input  logic             dst_vec,
  output logic             busy,
  output logic             pair_valid,
  output logic [REG_W-1:0] pair_src,
  output logic [REG_W-1:0] pair_dst,
  output logic             done
);
  import tpm_pkg::*;

  seq_state_t       state_q;
  logic [IW-1:0]    vl_q;
  logic             spent_q;
  logic             load, step, finish;
  logic             s_vec, d_vec;
  logic [IW-1:0]    s_nxt, d_nxt;
  logic [REG_W-1:0] s_reg, d_reg;

  assign load   = (state_q == SEQ_IDLE) && start;
  assign finish = (s_nxt >= vl_q) || (d_nxt >= vl_q) || spent_q;
  assign step   = (state_q == SEQ_RUN) && !finish;
  assign busy   = (state_q == SEQ_RUN);

  tpm_lane #(.MAXVL(MAXVL), .REG_W(REG_W), .IW(IW)) u_src (
    .clk (clk), .rst (rst), .load (load), .step (step),
    .vec_in (src_vec), .pred_in (src_pred), .base_in (src_base),
    .vec (s_vec), .nxt (s_nxt), .reg_no (s_reg)
  );

  tpm_lane #(.MAXVL(MAXVL), .REG_W(REG_W), .IW(IW)) u_dst (
    .clk (clk), .rst (rst), .load (load), .step (step),
    .vec_in (dst_vec), .pred_in (dst_pred), .base_in (dst_base),
    .vec (d_vec), .nxt (d_nxt), .reg_no (d_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      vl_q       <= '0;
      spent_q    <= 1'b0;
      pair_valid <= 1'b0;
      pair_src   <= '0;
      pair_dst   <= '0;
      done       <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      done       <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            vl_q    <= vl;
            spent_q <= 1'b0;
          end
        end
        default: begin
          if (finish) begin
            done    <= 1'b1;
            state_q <= SEQ_IDLE;
          end else begin
            pair_valid <= 1'b1;
            pair_src   <= s_reg;
            pair_dst   <= d_reg;
            // scalar-to-scalar: one copy only
            if (!s_vec && !d_vec) spent_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/twin_pred_mv_seq_chk.sv
module twin_pred_mv_seq_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             src_vec,
  input logic             dst_vec,
  input logic             busy,
  input logic             pair_valid,
  input logic [REG_W-1:0] pair_src,
  input logic [REG_W-1:0] pair_dst,
  input logic             done
);
  logic cap_sv, cap_dv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sv <= 1'b0;
      cap_dv <= 1'b0;
    end else if (start && !busy) begin
      cap_sv <= src_vec;
      cap_dv <= dst_vec;
    end
  end

  always @(posedge clk) begin
    if (rst) assert_reset_quiet_R1: assert (!busy && !pair_valid && !done);
  end

  assert_launch_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_scalar_src_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && $past(pair_valid) && !cap_sv) |-> $stable(pair_src));
  assert_scalar_dst_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && $past(pair_valid) && !cap_dv) |-> $stable(pair_dst));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_no_pair_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !pair_valid));
  assert_single_copy_R8: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !cap_sv && !cap_dv) |=> !pair_valid);
  assert_pair_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> busy);
  assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind twin_pred_mv_seq twin_pred_mv_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk (clk), .rst (rst), .start (start), .src_vec (src_vec),
  .dst_vec (dst_vec), .busy (busy), .pair_valid (pair_valid),
  .pair_src (pair_src), .pair_dst (pair_dst), .done (done)
);

// File: tb/sim_twin_pred_mv_seq.sv
`timescale 1ns/1ps
module sim_twin_pred_mv_seq;
  localparam int MAXVL = 8;
  localparam int REG_W = 5;
  localparam int IW    = $clog2(MAXVL + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [IW-1:0]    vl = '0;
  logic [MAXVL-1:0] src_pred = '0, dst_pred = '0;
  logic [REG_W-1:0] src_base = '0, dst_base = '0;
  logic             src_vec = 1'b0, dst_vec = 1'b0;
  logic             busy, pair_valid, done;
  logic [REG_W-1:0] pair_src, pair_dst;

  int checks = 0;
  int failures = 0;
  int m_n;
  int m_src [0:MAXVL];
  int m_dst [0:MAXVL];

  always #5 clk = ~clk;

  twin_pred_mv_seq #(.MAXVL(MAXVL), .REG_W(REG_W)) u0 (
    .clk (clk), .rst (rst), .start (start), .vl (vl),
    .src_pred (src_pred), .dst_pred (dst_pred),
    .src_base (src_base), .dst_base (dst_base),
    .src_vec (src_vec), .dst_vec (dst_vec),
    .busy (busy), .pair_valid (pair_valid),
    .pair_src (pair_src), .pair_dst (pair_dst), .done (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected copy list, built from the pairing rules
  task automatic model(input int n, input int sp, input int dp,
                       input int sb, input int db, input bit sv, input bit dv);
    int i = 0;
    int j = 0;
    bit one = 0;
    m_n = 0;
    forever begin
      if (sv) while (i < n && !sp[i]) i++;
      if (dv) while (j < n && !dp[j]) j++;
      if (i >= n || j >= n || one) break;
      m_src[m_n] = (sb + i) % (1 << REG_W);
      m_dst[m_n] = (db + j) % (1 << REG_W);
      m_n++;
      if (sv) i++;
      if (dv) j++;
      if (!sv && !dv) one = 1;
    end
  endtask

  task automatic run_op(input int n, input int sp, input int dp, input int sb,
                        input int db, input bit sv, input bit dv, input bit inject,
                        input string tag);
    model(n, sp, dp, sb, db, sv, dv);
    @(negedge clk);
    vl = IW'(n); src_pred = MAXVL'(sp); dst_pred = MAXVL'(dp);
    src_base = REG_W'(sb); dst_base = REG_W'(db); src_vec = sv; dst_vec = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pair_valid && !done, {tag, " R2 R10 launch"}, busy, 1);
    if (inject) begin
      // second launch while busy must be ignored (R2)
      start = 1'b1; vl = IW'(MAXVL); src_pred = '1; dst_pred = '1;
      src_base = 5'd3; dst_base = 5'd9; src_vec = 1'b1; dst_vec = 1'b1;
    end
    for (int k = 0; k <= m_n; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k < m_n) begin
        chk(pair_valid && !done, {tag, " R9 pair present"}, pair_valid, 1);
        chk(pair_src == REG_W'(m_src[k]), {tag, " R3 R5 R6 src reg"}, pair_src, m_src[k]);
        chk(pair_dst == REG_W'(m_dst[k]), {tag, " R4 R5 R6 dst reg"}, pair_dst, m_dst[k]);
      end else begin
        chk(done && !pair_valid && !busy, {tag, " R7 R10 finish"}, done, 1);
      end
    end
    @(negedge clk);
    chk(!done && !pair_valid && !busy, {tag, " R7 idle after done"}, done, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!busy && !pair_valid && !done, "R1 during reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !pair_valid && !done, "R1 after reset", busy, 0);

    run_op(5, 0,        8'hFF, 7,  10, 0, 1, 0, "splat");
    run_op(8, 8'hA5,    8'h5A, 4,  16, 0, 1, 0, "sparse splat");
    run_op(8, 8'h20,    8'h00, 12, 2,  1, 0, 0, "extract");
    run_op(8, 8'h00,    8'h08, 6,  20, 0, 1, 0, "insert");
    run_op(8, 8'hFF,    8'hFF, 1,  9,  1, 1, 0, "copy");
    run_op(8, 8'b10110010, 8'hFF, 2, 18, 1, 1, 0, "gather");
    run_op(8, 8'hFF,    8'b01101001, 8, 0, 1, 1, 0, "scatter");
    run_op(8, 8'b11001010, 8'b00110101, 3, 13, 1, 1, 0, "gather-scatter");
    run_op(0, 8'hFF,    8'hFF, 1,  2,  1, 1, 0, "vl zero R7");
    run_op(4, 8'h00,    8'h00, 5,  6,  0, 0, 0, "both scalar R8");
    run_op(6, 8'h00,    8'hFF, 5,  6,  1, 1, 0, "empty src pred R7");
    run_op(8, 8'hFF,    8'hFF, 28, 30, 1, 1, 0, "wrap R5");
    run_op(7, 8'b01011011, 8'hFF, 0, 24, 1, 1, 1, "start while busy R2");
    run_op(3, 8'hFF,    8'b11110000, 0, 1, 1, 1, 0, "dst bits above vl R7");

    for (int t = 0; t < 60; t++) begin
      int n;
      n = $urandom_range(0, MAXVL);
      run_op(n, $urandom_range(0, 255), $urandom_range(0, 255),
             $urandom_range(0, 31), $urandom_range(0, 31),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule